// File: doc/BRIEF.md
# Silent-Store-Pair Lock Detector

This block observes a merged stream of retired-instruction beats from several CPUs and discovers lock-protected critical sections with no help from software. A section opens when an atomic read-modify-write (test-and-set byte, swap or compare-and-swap) actually changes the value in memory. It closes when that same location is later put back to its pre-acquire value, which makes the pair of writes silent as a whole. Every opening and every closing is reported as one event. The event carries the CPU, the lock address, the kind of release and the length of the section counted in retired instructions.

Each CPU owns one tracker entry, so each CPU follows at most one lock at a time. The release kind tells apart a plain store by the owner, an atomic write by the owner that restores the old value, an atomic write by the owner that does not, and a restore done by another CPU. A section that stays open longer than a retired-instruction window is dropped without any report. Every beat supplies the memory value before and after its operation, so a compare-and-swap whose compare failed shows up as a write that leaves the value unchanged.

Top module: `lock_pair_detect`

## Requirements
- R1: Only a beat with op code 2 (test-and-set byte), 3 (swap) or 4 (compare-and-swap) whose after-value differs from its before-value opens a section. A plain store (op 1) never opens one. An opening emits kind 0 (acquire) with the beat's CPU and address and length 0.
- R2: An atomic beat whose after-value equals its before-value is a failed acquisition. It emits nothing and opens no tracking.
- R3: While a CPU tracks a lock, a plain store by that CPU to the lock address whose after-value equals the pre-acquire value closes the section with kind 1. A plain store to that address with any other value is ignored.
- R4: An atomic beat by the owner to the lock address closes the section. The kind is 2 if its after-value equals the pre-acquire value and 3 otherwise.
- R5: A plain or atomic write by a different CPU to a tracked address whose after-value equals that entry's pre-acquire value closes the entry with kind 4. The event carries the owner CPU and the owner's count.
- R6: The reported length is the number of retired beats (retired flag set) from the owner after the acquire beat, up to and including the release beat. Beats from other CPUs do not count, and neither do beats without the retired flag.
- R7: An entry whose owner retires WIN instructions (default 16384) with no release is cleared and emits nothing. A release on the WIN-th retired beat is still reported, with length WIN.
- R8: An atomic acquisition by a CPU whose entry is already busy is ignored. Stores to that other address are ignored as well.
- R9: The asynchronous active-low reset clears all entries and the event strobe. Each event appears on the outputs one clock after its beat, and at most one event is emitted per beat.
- R10: A beat that qualifies as a release of any entry does not also open a section, even when it is an atomic beat that changes the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beat_valid_i | input | 1 | Beat present this cycle |
| beat_cpu_i | input | CPU_W | Issuing CPU |
| beat_retired_i | input | 1 | Beat is a retired instruction |
| beat_op_i | input | 3 | 0 none, 1 store, 2 test-and-set, 3 swap, 4 compare-and-swap |
| beat_addr_i | input | ADDR_W | Memory address |
| beat_old_i | input | DATA_W | Memory value before the operation |
| beat_new_i | input | DATA_W | Memory value after the operation |
| evt_valid_o | output | 1 | Event strobe |
| evt_kind_o | output | 3 | 0 acquire, 1 store release, 2 atomic pair release, 3 atomic other release, 4 cross release |
| evt_cpu_o | output | CPU_W | Owner CPU |
| evt_addr_o | output | ADDR_W | Lock address |
| evt_len_o | output | CNT_W | Section length in retired instructions |

## Verification
Every result, whether an acquire, a release or the absence of an event, is due exactly one rising edge after the beat that causes it. The only exception is a dropped or reset entry, which changes nothing at the outputs and only alters how later beats are answered. The bench drives each beat at a falling edge and updates a behavioural model at the same moment. At the next falling edge it compares all five outputs against the model's prediction before it drives the following beat. Timeout is checked at the exact boundary: one release lands on the last counted retired beat and is reported, and another lands one beat later and is dropped.

// File: rtl/lockdet_pkg.sv
`timescale 1ns/1ps
package lockdet_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_STORE = 3'd1,
    OP_TAS   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_CAS   = 3'd4
  } mem_op_e;

  typedef enum logic [2:0] {
    EV_ACQUIRE   = 3'd0,
    EV_REL_STORE = 3'd1,
    EV_REL_PAIR  = 3'd2,
    EV_REL_OTHER = 3'd3,
    EV_REL_CROSS = 3'd4
  } evt_kind_e;

  function automatic logic is_atomic(logic [2:0] op);
    return (op == OP_TAS) || (op == OP_SWAP) || (op == OP_CAS);
  endfunction
endpackage

// File: rtl/lockdet_entry.sv
`timescale 1ns/1ps
module lockdet_entry
  import lockdet_pkg::*;
#(
  parameter int ID     = 0,
  parameter int CPU_W  = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN    = 16384,
  parameter int CNT_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CPU_W-1:0]  cpu_i,
  input  logic              retired_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic              set_i,
  input  logic              clr_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              own_rel_o,
  output logic              own_pair_o,
  output logic              cross_rel_o,
  output logic              acq_req_o,
  output logic [CNT_W-1:0]  len_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] pre_q;
  logic [CNT_W-1:0]  cnt_q;
  logic own, hit, atom, wr, restores;

  assign own      = valid_i && (cpu_i == CPU_W'(ID));
  assign hit      = busy_q && (addr_i == addr_q);
  assign atom     = is_atomic(op_i);
  assign wr       = atom || (op_i == OP_STORE);
  assign restores = (new_i == pre_q);

  assign own_rel_o   = own && hit && (atom || ((op_i == OP_STORE) && restores));
  assign own_pair_o  = restores;
  assign cross_rel_o = valid_i && !own && hit && wr && restores;
  assign acq_req_o   = own && !busy_q && atom && (new_i != old_i);
  assign len_o       = cnt_q + CNT_W'(own && retired_i);
  assign busy_o      = busy_q;
  assign addr_o      = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      pre_q  <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
    end else if (set_i) begin
      busy_q <= 1'b1;
      addr_q <= addr_i;
      pre_q  <= old_i;
      cnt_q  <= '0;
    end else if (busy_q && own && retired_i) begin
      // window expiry drops the entry silently
      if (cnt_q == CNT_W'(WIN - 1)) busy_q <= 1'b0;
      else                          cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_SET_ONLY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !busy_q); // R8
  AST_CNT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CNT_W'(WIN))); // R7
  AST_CLR_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !busy_o); // R9
endmodule

// File: rtl/lock_pair_detect.sv
`timescale 1ns/1ps
module lock_pair_detect
  import lockdet_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN    = 16384,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_valid_i,
  input  logic [CPU_W-1:0]  beat_cpu_i,
  input  logic              beat_retired_i,
  input  logic [2:0]        beat_op_i,
  input  logic [ADDR_W-1:0] beat_addr_i,
  input  logic [DATA_W-1:0] beat_old_i,
  input  logic [DATA_W-1:0] beat_new_i,
  output logic              evt_valid_o,
  output logic [2:0]        evt_kind_o,
  output logic [CPU_W-1:0]  evt_cpu_o,
  output logic [ADDR_W-1:0] evt_addr_o,
  output logic [CNT_W-1:0]  evt_len_o
);
  logic [N_CPU-1:0]  ent_busy, ent_own_rel, ent_pair, ent_cross, ent_acq, ent_set, ent_clr;
  logic [ADDR_W-1:0] ent_addr [N_CPU];
  logic [CNT_W-1:0]  ent_len  [N_CPU];

  for (genvar g = 0; g < N_CPU; g++) begin : g_ent
    lockdet_entry #(
      .ID(g), .CPU_W(CPU_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN(WIN), .CNT_W(CNT_W)
    ) u_ent (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .valid_i(beat_valid_i), .cpu_i(beat_cpu_i), .retired_i(beat_retired_i),
      .op_i(beat_op_i), .addr_i(beat_addr_i), .old_i(beat_old_i), .new_i(beat_new_i),
      .set_i(ent_set[g]), .clr_i(ent_clr[g]),
      .busy_o(ent_busy[g]), .addr_o(ent_addr[g]),
      .own_rel_o(ent_own_rel[g]), .own_pair_o(ent_pair[g]),
      .cross_rel_o(ent_cross[g]), .acq_req_o(ent_acq[g]), .len_o(ent_len[g])
    );
  end

  logic             rel_found;
  logic [CPU_W-1:0] rel_idx;
  logic [2:0]       rel_kind;

  // owner release first, then lowest-index cross release
  always_comb begin
    rel_found = 1'b0;
    rel_idx   = '0;
    rel_kind  = EV_REL_STORE;
    for (int i = 0; i < N_CPU; i++) begin
      if (!rel_found && ent_own_rel[i]) begin
        rel_found = 1'b1;
        rel_idx   = CPU_W'(i);
        if (beat_op_i == OP_STORE) rel_kind = EV_REL_STORE;
        else if (ent_pair[i])      rel_kind = EV_REL_PAIR;
        else                       rel_kind = EV_REL_OTHER;
      end
    end
    for (int i = 0; i < N_CPU; i++) begin
      if (!rel_found && ent_cross[i]) begin
        rel_found = 1'b1;
        rel_idx   = CPU_W'(i);
        rel_kind  = EV_REL_CROSS;
      end
    end
    ent_clr = '0;
    if (rel_found) ent_clr[rel_idx] = 1'b1;
    ent_set = rel_found ? '0 : ent_acq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_valid_o <= 1'b0;
      evt_kind_o  <= '0;
      evt_cpu_o   <= '0;
      evt_addr_o  <= '0;
      evt_len_o   <= '0;
    end else begin
      evt_valid_o <= rel_found || (|ent_set);
      if (rel_found) begin
        evt_kind_o <= rel_kind;
        evt_cpu_o  <= rel_idx;
        evt_addr_o <= ent_addr[rel_idx];
        evt_len_o  <= ent_len[rel_idx];
      end else begin
        evt_kind_o <= EV_ACQUIRE;
        evt_cpu_o  <= beat_cpu_i;
        evt_addr_o <= beat_addr_i;
        evt_len_o  <= '0;
      end
    end
  end

  AST_ACQ_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == EV_ACQUIRE) |->
      $past(beat_valid_i && is_atomic(beat_op_i) && beat_new_i != beat_old_i)); // R1
  AST_FAILED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && is_atomic(beat_op_i) && beat_new_i == beat_old_i) |=>
      !(evt_valid_o && evt_kind_o == EV_ACQUIRE)); // R2
  AST_STORE_REL_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == EV_REL_STORE) |->
      ($past(beat_op_i) == OP_STORE && $past(beat_addr_i) == evt_addr_o)); // R3
  AST_CROSS_OTHER_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == EV_REL_CROSS) |-> ($past(beat_cpu_i) != evt_cpu_o)); // R5
  AST_ONE_OWNER_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ent_set) && $onehot0(ent_own_rel)); // R9
endmodule

// File: tb/sim_lock_pair_detect.sv
`timescale 1ns/1ps
module sim_lock_pair_detect;
  localparam int N   = 4;
  localparam int WIN = 16384;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  cpu = '0;
  logic        ret = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] addr = '0, oldv = '0, newv = '0;
  logic        evt_valid;
  logic [2:0]  evt_kind;
  logic [1:0]  evt_cpu;
  logic [31:0] evt_addr;
  logic [14:0] evt_len;

  always #2.5 clk = ~clk;

  lock_pair_detect u0 (
    .clk_i(clk), .rst_ni(rst_ni), .beat_valid_i(valid), .beat_cpu_i(cpu),
    .beat_retired_i(ret), .beat_op_i(op), .beat_addr_i(addr),
    .beat_old_i(oldv), .beat_new_i(newv),
    .evt_valid_o(evt_valid), .evt_kind_o(evt_kind), .evt_cpu_o(evt_cpu),
    .evt_addr_o(evt_addr), .evt_len_o(evt_len)
  );

  int    errors = 0, checks = 0;
  string cur_req = "R9";

  bit          m_busy [N];
  logic [31:0] m_addr [N];
  logic [31:0] m_pre  [N];
  int          m_cnt  [N];
  bit          x_v;
  int          x_kind, x_cpu, x_len;
  logic [31:0] x_addr;

  task automatic check_out();
    checks++;
    if (evt_valid !== x_v || (x_v && (evt_kind != 3'(x_kind) || evt_cpu != 2'(x_cpu) ||
        evt_addr != x_addr || evt_len != 15'(x_len)))) begin
      errors++;
      $display("FAIL %s: act v=%0b k=%0d c=%0d a=%h l=%0d exp v=%0b k=%0d c=%0d a=%h l=%0d",
               cur_req, evt_valid, evt_kind, evt_cpu, evt_addr, evt_len,
               x_v, x_kind, x_cpu, x_addr, x_len);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_cnt[i] = 0;
    end
    x_v = 0;
  endtask

  task automatic model(int c, bit r, int o, logic [31:0] a, logic [31:0] ov, logic [31:0] nv);
    bit atom = (o == 2) || (o == 3) || (o == 4);
    bit wr   = atom || (o == 1);
    bit was  = m_busy[c];
    int ri   = -1;
    x_v = 0;
    if (was && m_addr[c] == a && (atom || (o == 1 && nv == m_pre[c]))) begin
      ri = c;
      x_kind = (o == 1) ? 1 : ((nv == m_pre[c]) ? 2 : 3);
      x_len  = m_cnt[c] + int'(r);
    end else begin
      for (int i = 0; i < N; i++)
        if (ri < 0 && i != c && m_busy[i] && m_addr[i] == a && wr && nv == m_pre[i]) begin
          ri = i; x_kind = 4; x_len = m_cnt[i];
        end
    end
    if (ri >= 0) begin
      x_v = 1; x_cpu = ri; x_addr = m_addr[ri]; m_busy[ri] = 0;
    end else if (atom && nv != ov && !was) begin
      x_v = 1; x_kind = 0; x_cpu = c; x_addr = a; x_len = 0;
      m_busy[c] = 1; m_addr[c] = a; m_pre[c] = ov; m_cnt[c] = 0;
    end
    if (was && ri != c && r) begin
      m_cnt[c]++;
      if (m_cnt[c] == WIN) m_busy[c] = 0;
    end
  endtask

  task automatic beat(int c, bit r, int o, logic [31:0] a, logic [31:0] ov, logic [31:0] nv);
    @(negedge clk);
    check_out();
    valid = 1; cpu = 2'(c); ret = r; op = 3'(o); addr = a; oldv = ov; newv = nv;
    model(c, r, o, a, ov, nv);
  endtask

  task automatic idle();
    @(negedge clk);
    check_out();
    valid = 0; x_v = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_out();
    valid = 0; rst_ni = 0; model_clear();
    cur_req = "R9";
    repeat (2) begin @(negedge clk); check_out(); end
    rst_ni = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act running exp finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();
    // R1: plain store does not open, test-and-set does
    cur_req = "R1";
    beat(0, 1, 1, 32'h100, 0, 1);
    beat(0, 1, 1, 32'h100, 1, 0);
    beat(0, 1, 2, 32'h100, 0, 32'hff);
    // R6: only owner retired beats count
    cur_req = "R6";
    repeat (3) beat(0, 1, 0, 0, 0, 0);
    repeat (2) beat(1, 1, 0, 0, 0, 0);
    beat(0, 0, 0, 0, 0, 0);
    // R3: non-restoring store ignored, restoring store releases
    cur_req = "R3";
    beat(0, 1, 1, 32'h100, 32'hff, 5);
    beat(0, 1, 1, 32'h100, 5, 32'hff);
    beat(0, 1, 1, 32'h100, 32'hff, 0);
    idle();
    // R2: failed compare-and-swap
    cur_req = "R2";
    beat(1, 1, 4, 32'h200, 7, 7);
    beat(1, 1, 1, 32'h200, 7, 7);
    beat(1, 1, 3, 32'h200, 7, 7);
    idle();
    // R4: atomic releases, pair and non-pair
    cur_req = "R4";
    beat(1, 1, 3, 32'h200, 0, 1);
    beat(1, 1, 0, 0, 0, 0);
    beat(1, 1, 3, 32'h200, 1, 0);
    beat(2, 1, 4, 32'h300, 0, 1);
    beat(2, 1, 2, 32'h300, 1, 32'hff);
    idle();
    // R8: busy entry ignores a second acquisition
    cur_req = "R8";
    beat(3, 1, 2, 32'h400, 0, 32'hff);
    beat(3, 1, 2, 32'h500, 0, 32'hff);
    beat(3, 1, 1, 32'h500, 32'hff, 0);
    beat(3, 1, 1, 32'h400, 32'hff, 0);
    idle();
    // R5 and R10: cross release wins over acquisition
    cur_req = "R5";
    beat(0, 1, 2, 32'h600, 0, 32'hff);
    beat(0, 1, 0, 0, 0, 0);
    beat(2, 1, 1, 32'h600, 32'hff, 3);
    cur_req = "R10";
    beat(1, 1, 3, 32'h600, 32'hff, 0);
    beat(2, 1, 1, 32'h600, 0, 0);
    idle();
    // R7: release on the last counted beat, then a dropped section
    cur_req = "R7";
    beat(0, 1, 2, 32'h700, 0, 32'hff);
    repeat (WIN - 1) beat(0, 1, 0, 0, 0, 0);
    beat(0, 1, 1, 32'h700, 32'hff, 0);
    beat(0, 1, 2, 32'h800, 0, 32'hff);
    repeat (WIN) beat(0, 1, 0, 0, 0, 0);
    beat(0, 1, 1, 32'h800, 32'hff, 0);
    beat(0, 1, 2, 32'h900, 0, 32'hff);
    idle();
    // R9: reset clears a live entry
    cur_req = "R9";
    beat(1, 1, 2, 32'ha00, 0, 32'hff);
    do_reset();
    beat(1, 1, 1, 32'ha00, 32'hff, 0);
    beat(1, 1, 2, 32'ha00, 0, 32'hff);
    idle();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule